// File: doc/BRIEF.md
# Branch Trace Ring

The block keeps a short history of retired control-flow changes. Each accepted branch event stores its source address, target address and a small info word into one slot of a circular store of `DEPTH` entries, and a top-of-stack pointer always points at the newest slot. Three status flags (mispredicted, inside a transaction, transaction aborted) are packed into the upper bits of the stored source word. Software walks the history backwards from the pointer through a one-cycle indexed read port.

A ten-bit select value filters what gets stored. Nine of its bits work as suppress bits: a set bit blocks one branch class or one target privilege level. The tenth bit turns on call-stack mode. In this mode only calls push entries, and a return removes the newest entry, so the store follows the live call chain. Recording runs only while enabled. An optional freeze stops recording when a performance-monitor interrupt arrives and stays in force until software releases it. A clear strobe wipes every slot.

Top module: `branch_trace_ring`

## Requirements
- R1: After reset, `tos` is 0, `frozen` is 0 and every slot reads back as all zeros on `rd_from`, `rd_to` and `rd_info`.
- R2: In linear mode (`ctl_select[9]`=0), each recorded branch is written at index (`tos`+1) mod `DEPTH` and `tos` moves there. The branch recorded i events before the newest is therefore read at (`tos`−i) & (`DEPTH`−1), and the index wraps after `DEPTH` records. `tos` never moves without a valid branch.
- R3: A stored entry reads back with `rd_from[63]`=mispredict, `rd_from[62]`=in-transaction, `rd_from[61]`=abort and `rd_from[60:0]`=source address. `rd_to` is the target address, `rd_info[3:0]` is the class code and `rd_info[4]` is 1 when the target is ring 0.
- R4: Class codes are 0 conditional, 1 relative call, 2 indirect call, 3 near return, 4 indirect jump, 5 relative jump and 6 far branch. `ctl_select[k+2]`=1 blocks class k. Codes 7 to 15 are never recorded.
- R5: `ctl_select[0]`=1 blocks branches whose target is ring 0, and `ctl_select[1]`=1 blocks branches whose target is not ring 0. The source privilege plays no part.
- R6: While `ctl_enable`=0 nothing is recorded and `frozen` is 0 from the next cycle.
- R7: While enabled with `ctl_freeze_on_int`=1, a `pmi` pulse blocks the branch in the same cycle and sets `frozen`. While `frozen` is set no branch is recorded. A `frz_release` pulse clears `frozen` one cycle later. If both arrive together, `pmi` wins.
- R8: In call-stack mode (`ctl_select[9]`=1), classes 1 and 2 push as in R2 and class 3 zeroes the slot at `tos` and moves `tos` down by one. Other classes are not recorded. A push into a full store overwrites the oldest entry.
- R9: In call-stack mode, a return with no live entries is dropped and `tos` does not move.
- R10: `ctl_clear` zeroes every slot and empties the call-stack fill count, but leaves `tos` unchanged. A branch in the same cycle as `ctl_clear` is not recorded.
- R11: Read data for `rd_idx` appears one cycle later. A read in the same cycle as a write to that slot returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_valid | input | 1 | A branch event is present this cycle |
| br_from | input | ADDR_W-3 | Branch source address |
| br_to | input | ADDR_W | Branch target address |
| br_class | input | 4 | Branch class code (see R4) |
| br_tgt_ring0 | input | 1 | Target runs at ring 0 |
| br_mispred | input | 1 | Branch was mispredicted |
| br_in_tx | input | 1 | Branch was inside a transaction |
| br_abort | input | 1 | Branch was a transaction abort |
| ctl_enable | input | 1 | Recording enable |
| ctl_freeze_on_int | input | 1 | Freeze recording on interrupt |
| ctl_select | input | 10 | Suppress bits [8:0] and call-stack mode [9] |
| ctl_clear | input | 1 | Strobe that zeroes all slots |
| pmi | input | 1 | Performance-monitor interrupt raised |
| frz_release | input | 1 | Software release of the freeze |
| rd_idx | input | log2(DEPTH) | Read slot index |
| rd_from | output | ADDR_W | Source word with flags, registered |
| rd_to | output | ADDR_W | Target address, registered |
| rd_info | output | 5 | Ring-0 target bit and class, registered |
| tos | output | log2(DEPTH) | Index of newest entry |
| frozen | output | 1 | Freeze is in force |

## Verification
The pointer and the freeze flag take one clock edge after a branch, interrupt, release or enable change. Read data is due one edge after `rd_idx` is presented. The driver changes inputs right after a falling edge and then waits for the next falling edge, so `tos` and `frozen` are compared half a cycle after the edge that updates them. For every read the driver queues the expected slot contents from the bench's own model, taken before that cycle's branch is applied. The monitor notes at each rising edge whether a read was issued and pops one expectation at the following falling edge, once the registered read data has settled. This lines every comparison up with the cycle in which the result is due, including a read and a write to the same slot in one cycle.

// File: rtl/branch_trace_ring.sv
module branch_trace_ring #(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     br_valid,
  input  logic [ADDR_W-4:0]        br_from,
  input  logic [ADDR_W-1:0]        br_to,
  input  logic [3:0]               br_class,
  input  logic                     br_tgt_ring0,
  input  logic                     br_mispred,
  input  logic                     br_in_tx,
  input  logic                     br_abort,
  input  logic                     ctl_enable,
  input  logic                     ctl_freeze_on_int,
  input  logic [9:0]               ctl_select,
  input  logic                     ctl_clear,
  input  logic                     pmi,
  input  logic                     frz_release,
  input  logic [$clog2(DEPTH)-1:0] rd_idx,
  output logic [ADDR_W-1:0]        rd_from,
  output logic [ADDR_W-1:0]        rd_to,
  output logic [4:0]               rd_info,
  output logic [$clog2(DEPTH)-1:0] tos,
  output logic                     frozen
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W:0] FULL = (IDX_W+1)'(DEPTH);

  logic [ADDR_W-1:0] from_q [DEPTH];
  logic [ADDR_W-1:0] to_q   [DEPTH];
  logic [4:0]        info_q [DEPTH];
  logic [IDX_W:0]    fill_q;
  logic              kind_blocked;

  wire cs_mode      = ctl_select[9];
  wire is_call      = (br_class == 4'd1) || (br_class == 4'd2);
  wire is_ret       = (br_class == 4'd3);
  wire priv_blocked = br_tgt_ring0 ? ctl_select[0] : ctl_select[1];
  wire int_stop     = pmi && ctl_freeze_on_int;

  always_comb begin
    case (br_class)
      4'd0:    kind_blocked = ctl_select[2];
      4'd1:    kind_blocked = ctl_select[3];
      4'd2:    kind_blocked = ctl_select[4];
      4'd3:    kind_blocked = ctl_select[5];
      4'd4:    kind_blocked = ctl_select[6];
      4'd5:    kind_blocked = ctl_select[7];
      4'd6:    kind_blocked = ctl_select[8];
      default: kind_blocked = 1'b1;
    endcase
  end

  wire live    = br_valid && ctl_enable && !frozen && !int_stop && !ctl_clear
                 && !priv_blocked && !kind_blocked;
  wire do_push = live && (!cs_mode || is_call);
  wire do_pop  = live && cs_mode && is_ret && (fill_q != '0);

  wire [IDX_W-1:0]  nxt      = tos + 1'b1;
  wire [ADDR_W-1:0] from_new = {br_mispred, br_in_tx, br_abort, br_from};
  wire [4:0]        info_new = {br_tgt_ring0, br_class};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) frozen <= 1'b0;
    else if (!ctl_enable) frozen <= 1'b0;
    else if (int_stop) frozen <= 1'b1;
    else if (frz_release) frozen <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_from <= '0;
      rd_to   <= '0;
      rd_info <= '0;
    end else begin
      rd_from <= from_q[rd_idx];
      rd_to   <= to_q[rd_idx];
      rd_info <= info_q[rd_idx];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos    <= '0;
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        from_q[i] <= '0;
        to_q[i]   <= '0;
        info_q[i] <= '0;
      end
    end else if (ctl_clear) begin
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        from_q[i] <= '0;
        to_q[i]   <= '0;
        info_q[i] <= '0;
      end
    end else if (do_push) begin
      from_q[nxt] <= from_new;
      to_q[nxt]   <= br_to;
      info_q[nxt] <= info_new;
      tos         <= nxt;
      if (fill_q != FULL) fill_q <= fill_q + 1'b1;
    end else if (do_pop) begin
      from_q[tos] <= '0;
      to_q[tos]   <= '0;
      info_q[tos] <= '0;
      tos         <= tos - 1'b1;
      fill_q      <= fill_q - 1'b1;
    end
  end
endmodule

// File: rtl/branch_trace_ring_chk.sv
module branch_trace_ring_chk #(
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     br_valid,
  input logic                     ctl_enable,
  input logic                     ctl_freeze_on_int,
  input logic [9:0]               ctl_select,
  input logic                     pmi,
  input logic                     frozen,
  input logic [$clog2(DEPTH)-1:0] tos
);
  localparam int IDX_W = $clog2(DEPTH);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !br_valid |=> $stable(tos)); // R2
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_select[9] |=> (tos == $past(tos) || tos == IDX_W'($past(tos) + 1'b1))); // R2
  AST_PRIV_BOTH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_select[0] && ctl_select[1]) |=> $stable(tos)); // R5
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> $stable(tos)); // R6
  AST_OFF_THAW: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enable |=> !frozen); // R6
  AST_FREEZE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_enable && ctl_freeze_on_int && pmi) |=> frozen); // R7
  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(tos)); // R7
  AST_STACK_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_select[9] |=> (tos == $past(tos) || tos == IDX_W'($past(tos) + 1'b1)
                       || tos == IDX_W'($past(tos) - 1'b1))); // R8
endmodule

bind branch_trace_ring branch_trace_ring_chk #(.DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_branch_trace_ring.sv
module tb_branch_trace_ring;
  localparam int D = 16;

  typedef struct {
    logic [63:0] f;
    logic [63:0] t;
    logic [4:0]  i;
    int          idx;
    string       req;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic br_valid = 0, br_tgt_ring0 = 0, br_mispred = 0, br_in_tx = 0, br_abort = 0;
  logic [60:0] br_from = 0;
  logic [63:0] br_to = 0;
  logic [3:0]  br_class = 0;
  logic ctl_enable = 0, ctl_freeze_on_int = 0, ctl_clear = 0, pmi = 0, frz_release = 0;
  logic [9:0]  ctl_select = 0;
  logic [3:0]  rd_idx = 0;
  logic [63:0] rd_from, rd_to;
  logic [4:0]  rd_info;
  logic [3:0]  tos;
  logic        frozen;
  logic        rd_issue = 0;

  logic [63:0] m_from [D];
  logic [63:0] m_to [D];
  logic [4:0]  m_info [D];
  int m_tos = 0, m_fill = 0;
  bit m_frz = 0;
  int checks = 0, errors = 0;
  bit done = 0;
  exp_t q[$];

  branch_trace_ring dut (.*);

  always #10 clk = ~clk;

  task automatic drive(input bit v, input logic [60:0] f, input logic [63:0] t,
                       input logic [3:0] c, input bit r0, input logic [2:0] fl,
                       input bit rd, input int idx, input string req);
    bit blk_c, blk_p, live;
    exp_t e;
    br_valid = v; br_from = f; br_to = t; br_class = c; br_tgt_ring0 = r0;
    {br_mispred, br_in_tx, br_abort} = fl;
    rd_issue = rd;
    if (rd) begin
      rd_idx = idx[3:0];
      e.f = m_from[idx]; e.t = m_to[idx]; e.i = m_info[idx]; e.idx = idx; e.req = req;
      q.push_back(e);
    end
    blk_c = (c < 7) ? ctl_select[c + 2] : 1'b1;
    blk_p = r0 ? ctl_select[0] : ctl_select[1];
    live = v && ctl_enable && !m_frz && !(pmi && ctl_freeze_on_int) && !ctl_clear && !blk_p && !blk_c;
    if (ctl_clear) begin
      for (int k = 0; k < D; k++) begin m_from[k] = 0; m_to[k] = 0; m_info[k] = 0; end
      m_fill = 0;
    end else if (live && (!ctl_select[9] || c == 1 || c == 2)) begin
      m_tos = (m_tos + 1) % D;
      m_from[m_tos] = {fl, f}; m_to[m_tos] = t; m_info[m_tos] = {r0, c};
      if (m_fill < D) m_fill++;
    end else if (live && ctl_select[9] && c == 3 && m_fill > 0) begin
      m_from[m_tos] = 0; m_to[m_tos] = 0; m_info[m_tos] = 0;
      m_tos = (m_tos + D - 1) % D;
      m_fill--;
    end
    if (!ctl_enable) m_frz = 0;
    else if (pmi && ctl_freeze_on_int) m_frz = 1;
    else if (frz_release) m_frz = 0;
    @(negedge clk);
    br_valid = 0; rd_issue = 0;
  endtask

  task automatic br(input logic [3:0] c, input bit r0, input logic [60:0] f,
                    input logic [63:0] t, input logic [2:0] fl);
    drive(1, f, t, c, r0, fl, 0, 0, "");
  endtask

  task automatic rd(input int idx, input string req);
    drive(0, 0, 0, 0, 0, 0, 1, idx, req);
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, 0, 0, 0, "");
  endtask

  task automatic chk_tos(input string req);
    checks++;
    if (tos !== m_tos[3:0]) begin
      errors++;
      $display("FAIL %s tos act=%0d exp=%0d", req, tos, m_tos);
    end
  endtask

  task automatic chk_frz(input string req);
    checks++;
    if (frozen !== m_frz) begin
      errors++;
      $display("FAIL %s frozen act=%0b exp=%0b", req, frozen, m_frz);
    end
  endtask

  initial begin
    forever begin
      bit got;
      @(posedge clk);
      got = rd_issue;
      @(negedge clk);
      if (got) begin
        exp_t e;
        checks++;
        if (q.size() == 0) begin
          errors++;
          $display("FAIL scoreboard read with no expectation act=%h exp=none", rd_from);
        end else begin
          e = q.pop_front();
          if (rd_from !== e.f || rd_to !== e.t || rd_info !== e.i) begin
            errors++;
            $display("FAIL %s slot %0d act=%h/%h/%h exp=%h/%h/%h", e.req, e.idx,
                     rd_from, rd_to, rd_info, e.f, e.t, e.i);
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=running exp=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < D; k++) begin m_from[k] = 0; m_to[k] = 0; m_info[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk_tos("R1"); chk_frz("R1");
    for (int k = 0; k < D; k++) rd(k, "R1");

    ctl_enable = 1;
    br(4'd0, 0, 61'h1000, 64'h2000, 3'b100);
    br(4'd1, 1, 61'h1010, 64'hFFFF_0000_0000_0040, 3'b010);
    br(4'd4, 0, 61'h1020, 64'h2040, 3'b001);
    chk_tos("R2");
    rd(1, "R3"); rd(2, "R3"); rd(3, "R3");
    for (int k = 0; k < 15; k++) br(4'd5, 0, 61'h3000 + k, 64'h4000 + k, 3'b000);
    chk_tos("R2 wrap");
    rd((m_tos + D - 1) % D, "R2"); rd(m_tos, "R2");

    ctl_select = 10'b0000000100;
    br(4'd0, 0, 61'h5000, 64'h5004, 3'b000); chk_tos("R4 cond blocked");
    br(4'd5, 0, 61'h5010, 64'h5014, 3'b000); chk_tos("R4 jump kept");
    ctl_select = 10'b0100000000;
    br(4'd6, 1, 61'h5020, 64'h5024, 3'b000); chk_tos("R4 far blocked");
    ctl_select = 0;
    br(4'd9, 0, 61'h5030, 64'h5034, 3'b000); chk_tos("R4 code 9");
    rd(m_tos, "R4");

    ctl_select = 10'b0000000001;
    br(4'd2, 1, 61'h6000, 64'h6004, 3'b000); chk_tos("R5 ring0 blocked");
    br(4'd2, 0, 61'h6010, 64'h6014, 3'b000); chk_tos("R5 user kept");
    ctl_select = 10'b0000000010;
    br(4'd2, 0, 61'h6020, 64'h6024, 3'b000); chk_tos("R5 user blocked");
    br(4'd2, 1, 61'h6030, 64'h6034, 3'b000); chk_tos("R5 ring0 kept");
    rd(m_tos, "R5");
    ctl_select = 0;

    ctl_enable = 0;
    br(4'd0, 0, 61'h7000, 64'h7004, 3'b000); chk_tos("R6 disabled");
    ctl_enable = 1;

    ctl_freeze_on_int = 1;
    pmi = 1; br(4'd0, 0, 61'h7100, 64'h7104, 3'b000); pmi = 0;
    chk_tos("R7 same cycle"); chk_frz("R7 set");
    br(4'd0, 0, 61'h7110, 64'h7114, 3'b000); chk_tos("R7 held");
    pmi = 1; frz_release = 1; idle(); pmi = 0; frz_release = 0; chk_frz("R7 pmi wins");
    frz_release = 1; idle(); frz_release = 0; chk_frz("R7 release");
    br(4'd0, 0, 61'h7120, 64'h7124, 3'b000); chk_tos("R7 resumed");
    pmi = 1; idle(); pmi = 0; chk_frz("R6 setup");
    ctl_enable = 0; idle(); chk_frz("R6 thaw");
    ctl_enable = 1;

    ctl_clear = 1; br(4'd0, 0, 61'h7200, 64'h7204, 3'b000); ctl_clear = 0;
    chk_tos("R10 tos kept");
    for (int k = 0; k < D; k++) rd(k, "R10");

    ctl_select = 10'b1000000000;
    br(4'd1, 0, 61'h8000, 64'h8004, 3'b100);
    br(4'd2, 0, 61'h8010, 64'h8014, 3'b000);
    br(4'd0, 0, 61'h8020, 64'h8024, 3'b000);
    chk_tos("R8 push");
    br(4'd3, 0, 61'h8030, 64'h8034, 3'b000);
    chk_tos("R8 pop");
    rd((m_tos + 1) % D, "R8 popped slot"); rd(m_tos, "R8");
    br(4'd3, 0, 61'h8040, 64'h8044, 3'b000);
    br(4'd3, 0, 61'h8050, 64'h8054, 3'b000);
    chk_tos("R9 empty return");
    for (int k = 0; k < D + 2; k++) br(4'd1, 0, 61'h9000 + k, 64'h9100 + k, 3'b000);
    chk_tos("R8 full");
    for (int k = 0; k < D + 1; k++) br(4'd3, 0, 61'h9200, 64'h9204, 3'b000);
    chk_tos("R9 drained");
    ctl_select = 0;

    br(4'd5, 0, 61'hA000, 64'hA004, 3'b000);
    drive(1, 61'hA010, 64'hA014, 4'd5, 0, 3'b111, 1, (m_tos + 1) % D, "R11 old");
    rd(m_tos, "R11 new");

    repeat (3) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R11 pending reads act=%0d exp=0", q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule